// File: doc/BRIEF.md
# BCD Reloadable Watchdog Countdown Timer

This block is a watchdog whose timeout period is kept as four BCD digits, from 00.01 s to 99.99 s. The digits sit in two byte-wide registers on a small register bus. An internal down-counter is loaded from those digits. It steps down once per 100 Hz tick strobe, and when it runs out it raises a watchdog alarm flag and an interrupt request. It then reloads itself, so an unserviced watchdog keeps alarming once per period.

Software services the watchdog by touching either period register. Any access, read or write, restarts the countdown from the programmed value and drops the flag and the interrupt. Reads return the programmed digits, never the live count. Programming all four digits to zero switches the watchdog off. The flag can be read back in a status byte. In pulse mode the flag stays up only for a fixed number of clock cycles; in level mode it stays up until the next service access.

Top module: `wdt_bcd_watchdog`

## Requirements
- R1: After a synchronous active-low reset, the period is 00.00 (disabled), `wdog_flag` and `wdog_irq` are 0, and reads of addresses 0xB, 0xC and 0xD return 0x00.
- R2: Any access (read or write) with `bus_valid` high to address 0xC or 0xD reloads the counter from the period registers as they stand after that access, in the cycle after the access. The same reload clears `wdog_flag` and `wdog_irq`.
- R3: With a nonzero period of decimal value N hundredths, `wdog_flag` and `wdog_irq` stay 0 through the first N-1 tick strobes after a reload and both become 1 on the clock edge of the N-th tick.
- R4: If no service access occurs, the counter reloads itself at expiry and the alarm repeats every N ticks.
- R5: A read of 0xC returns tenths in bits 7:4 and hundredths in bits 3:0; a read of 0xD returns tens of seconds in bits 7:4 and seconds in bits 3:0. Both always show the programmed value.
- R6: While both period registers hold zero, the flag never becomes 1.
- R7: The counter counts in BCD and borrows across all four digits, so a period of 01.00 expires after exactly 100 ticks and 99.99 after exactly 9999 ticks.
- R8: A tick that arrives in the reload cycle after a service access is ignored; a full period of N further ticks is needed for the next alarm.
- R9: Address 0xB reads the flag in bit 1 with all other bits 0. Writes to 0xB do not change the flag, and reads of 0xB do not clear it.
- R10: With `pulse_mode` 1, the flag stays high for exactly PULSE_CYCLES clock cycles after expiry and then falls. With `pulse_mode` 0, it stays high until a service access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_100hz | input | 1 | One-cycle strobe at 100 Hz that advances the countdown |
| pulse_mode | input | 1 | 1 selects pulse flag behaviour, 0 selects level |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address, combinational |
| wdog_flag | output | 1 | Watchdog alarm flag |
| wdog_irq | output | 1 | Interrupt request to the interrupt controller |

## Verification
The assertions take for granted two things about the inputs. Every digit written to the period registers must be a valid BCD digit. In pulse mode, the period in clock cycles must be longer than the pulse, so that a new expiry never lands while a pulse is still running. The stimulus writes only BCD digits and sweeps periods that cross every digit borrow. It holds `pulse_mode` steady across each expiry and spaces its tick strobes so that a 5-tick period spans more cycles than the pulse.

// File: rtl/wdt_pkg.sv
// Shared constants for the BCD watchdog.
// Assumes a 4-bit register address space and byte-wide registers.
package wdt_pkg;
    localparam int DIGIT_W = 4;
    localparam int BYTE_W  = 8;
    localparam int BCD_MAX = 9;
endpackage

// File: rtl/wdt_bcd_dec.sv
// Combinational BCD decrement by one across DIGITS digits.
// Also flags a value of exactly one and a value of zero.
// Assumes every input digit is a valid BCD digit.
module wdt_bcd_dec
    import wdt_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic [DIGITS*DIGIT_W-1:0] val,
    output logic [DIGITS*DIGIT_W-1:0] nxt,
    output logic                      is_one,
    output logic                      is_zero
);
    localparam int W = DIGITS * DIGIT_W;

    // Ripple the borrow from the lowest digit upward.
    always_comb begin
        logic               brw;
        logic [DIGIT_W-1:0] d;
        brw = 1'b1;
        nxt = '0;
        for (int i = 0; i < DIGITS; i++) begin
            d = val[i*DIGIT_W +: DIGIT_W];
            if (!brw) begin
                nxt[i*DIGIT_W +: DIGIT_W] = d;
            end else if (d == '0) begin
                nxt[i*DIGIT_W +: DIGIT_W] = DIGIT_W'(BCD_MAX);
            end else begin
                nxt[i*DIGIT_W +: DIGIT_W] = d - 1'b1;
                brw = 1'b0;
            end
        end
    end

    // Terminal-value detection.
    assign is_one  = (val == W'(1));
    assign is_zero = (val == '0);
endmodule

// File: rtl/wdt_regs.sv
// Period registers, status read-back and service (kick) detection.
// Any access to a period byte raises kick for one cycle, one cycle later.
// Assumes single-cycle bus_valid strobes.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DIGITS    = 4,
    parameter int ADDR_W    = 4,
    parameter int BASE_ADDR = 12,
    parameter int FLAG_ADDR = 11,
    parameter int FLAG_BIT  = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [BYTE_W-1:0]         bus_wdata,
    input  logic                      flag,
    output logic [BYTE_W-1:0]         bus_rdata,
    output logic [DIGITS*DIGIT_W-1:0] period,
    output logic                      kick
);
    localparam int BYTES = DIGITS / 2;

    logic [BYTES-1:0][BYTE_W-1:0] period_q;
    logic [BYTES-1:0]             hit;

    genvar g;
    generate
        for (g = 0; g < BYTES; g++) begin : g_byte
            assign hit[g] = bus_valid && (bus_addr == ADDR_W'(BASE_ADDR + g));

            // Store the written digit pair of this byte.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    period_q[g] <= '0;
                else if (hit[g] && bus_write)
                    period_q[g] <= bus_wdata;
            end
        end
    endgenerate

    // Register the service strobe so the reload sees the updated period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            kick <= 1'b0;
        else
            kick <= |hit;
    end

    // Read mux: programmed period bytes and the status byte.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < BYTES; i++)
            if (bus_addr == ADDR_W'(BASE_ADDR + i))
                bus_rdata = period_q[i];
        if (bus_addr == ADDR_W'(FLAG_ADDR))
            bus_rdata[FLAG_BIT] = flag;
    end

    assign period = period_q;
endmodule

// File: rtl/wdt_count.sv
// BCD down-counter, loaded on kick and self-reloading at expiry.
// expire is a one-cycle strobe, suppressed in a kick cycle.
// Assumes the period holds valid BCD digits.
module wdt_count
    import wdt_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      kick,
    input  logic [DIGITS*DIGIT_W-1:0] period,
    output logic                      expire
);
    logic [DIGITS*DIGIT_W-1:0] count_q;
    logic [DIGITS*DIGIT_W-1:0] count_nxt;
    logic                      at_one;
    logic                      at_zero;
    logic                      active;

    wdt_bcd_dec #(.DIGITS(DIGITS)) u_dec (
        .val     (count_q),
        .nxt     (count_nxt),
        .is_one  (at_one),
        .is_zero (at_zero)
    );

    assign active = (period != '0);
    assign expire = tick && active && !kick && at_one;

    // Reload on service or expiry, otherwise step down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (kick)
            count_q <= period;
        else if (tick && active)
            count_q <= (at_one || at_zero) ? period : count_nxt;
    end
endmodule

// File: rtl/wdt_flag.sv
// Alarm flag with level or fixed-length pulse behaviour.
// Clear wins over a set in the same cycle.
// Assumes PULSE_CYCLES of at least 2.
module wdt_flag #(
    parameter int PULSE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clear,
    input  logic pulse_mode,
    output logic flag
);
    localparam int PCW = $clog2(PULSE_CYCLES);

    logic [PCW-1:0] pcnt_q;

    // Set on expiry, clear on service, time out in pulse mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag   <= 1'b0;
            pcnt_q <= '0;
        end else if (clear) begin
            flag   <= 1'b0;
        end else if (expire) begin
            flag   <= 1'b1;
            pcnt_q <= PCW'(PULSE_CYCLES - 1);
        end else if (flag && pulse_mode) begin
            if (pcnt_q == '0)
                flag <= 1'b0;
            else
                pcnt_q <= pcnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdt_bcd_watchdog.sv
// Top level of the BCD watchdog: registers, counter and flag.
// The interrupt request follows the flag.
// Assumes tick_100hz is a one-cycle strobe synchronous to clk.
module wdt_bcd_watchdog
    import wdt_pkg::*;
#(
    parameter int DIGITS       = 4,
    parameter int ADDR_W       = 4,
    parameter int BASE_ADDR    = 12,
    parameter int FLAG_ADDR    = 11,
    parameter int FLAG_BIT     = 1,
    parameter int PULSE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_100hz,
    input  logic              pulse_mode,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              wdog_flag,
    output logic              wdog_irq
);
    logic [DIGITS*DIGIT_W-1:0] period_w;
    logic                      kick_w;
    logic                      expire_w;

    wdt_regs #(
        .DIGITS(DIGITS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
        .FLAG_ADDR(FLAG_ADDR), .FLAG_BIT(FLAG_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flag      (wdog_flag),
        .bus_rdata (bus_rdata),
        .period    (period_w),
        .kick      (kick_w)
    );

    wdt_count #(.DIGITS(DIGITS)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_100hz),
        .kick   (kick_w),
        .period (period_w),
        .expire (expire_w)
    );

    wdt_flag #(.PULSE_CYCLES(PULSE_CYCLES)) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire_w),
        .clear      (kick_w),
        .pulse_mode (pulse_mode),
        .flag       (wdog_flag)
    );

    assign wdog_irq = wdog_flag;
endmodule

// File: rtl/wdt_bcd_watchdog_chk.sv
// Property checker for the BCD watchdog, bound to the top module.
// Assumes valid BCD periods and, in pulse mode, periods longer than the pulse.
module wdt_bcd_watchdog_chk #(
    parameter int DIGITS       = 4,
    parameter int ADDR_W       = 4,
    parameter int BASE_ADDR    = 12,
    parameter int PULSE_CYCLES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_100hz,
    input logic                  pulse_mode,
    input logic                  bus_valid,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  wdog_flag,
    input logic [DIGITS*4-1:0]   period
);
    localparam int BYTES = DIGITS / 2;

    logic        svc_hit;
    logic [15:0] run_q;

    assign svc_hit = bus_valid && (bus_addr >= ADDR_W'(BASE_ADDR)) &&
                     (bus_addr < ADDR_W'(BASE_ADDR + BYTES));

    // Length of the current high stretch of the flag in pulse mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (wdog_flag && pulse_mode)
            run_q <= run_q + 1'b1;
        else
            run_q <= '0;
    end

    AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        svc_hit |-> ##2 !wdog_flag); // R2

    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_flag) |-> $past(tick_100hz)); // R3

    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0 && !wdog_flag) |=> !wdog_flag); // R6

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 16'(PULSE_CYCLES)); // R10
endmodule

bind wdt_bcd_watchdog wdt_bcd_watchdog_chk #(
    .DIGITS(DIGITS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_100hz (tick_100hz),
    .pulse_mode (pulse_mode),
    .bus_valid  (bus_valid),
    .bus_addr   (bus_addr),
    .wdog_flag  (wdog_flag),
    .period     (period_w)
);

// File: tb/sim_wdt_bcd_watchdog.sv
// Self-checking bench: sweeps BCD periods across every borrow boundary.
module sim_wdt_bcd_watchdog;
    localparam int PULSE = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_100hz = 1'b0;
    logic       pulse_mode = 1'b0;
    logic       bus_valid = 1'b0;
    logic       bus_write = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wdog_flag;
    logic       wdog_irq;

    int tests = 0;
    int fails = 0;
    logic [7:0] rd;

    always #4 clk = ~clk;

    wdt_bcd_watchdog #(.PULSE_CYCLES(PULSE)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .pulse_mode(pulse_mode),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdog_flag(wdog_flag), .wdog_irq(wdog_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bcd2int(input logic [15:0] p);
        return p[15:12] * 1000 + p[11:8] * 100 + p[7:4] * 10 + p[3:0];
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic tick_once();
        tick_100hz = 1'b1;
        cyc();
        tick_100hz = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick_once();
    endtask

    // One bus access; read data sampled before the edge.
    task automatic acc(input logic w, input logic [3:0] a, input logic [7:0] d,
                       output logic [7:0] r);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
        #1;
        r = bus_rdata;
        cyc();
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic set_period(input logic [15:0] p);
        logic [7:0] r;
        acc(1'b1, 4'hC, p[7:0], r);
        acc(1'b1, 4'hD, p[15:8], r);
        idle(1);
    endtask

    logic [15:0] sweep [12] = '{16'h0001, 16'h0002, 16'h0009, 16'h0010,
                                16'h0011, 16'h0099, 16'h0100, 16'h0101,
                                16'h0999, 16'h1000, 16'h1001, 16'h9999};

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog timeout");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        cyc();
        // R1: reset state
        check("R1 flag", wdog_flag, 0);
        check("R1 irq", wdog_irq, 0);
        acc(1'b0, 4'hB, 8'h00, rd); check("R1 read B", rd, 8'h00);
        acc(1'b0, 4'hC, 8'h00, rd); check("R1 read C", rd, 8'h00);
        acc(1'b0, 4'hD, 8'h00, rd); check("R1 read D", rd, 8'h00);
        idle(1);

        // R3/R7/R5/R9/R2: level-mode sweep across borrow boundaries
        foreach (sweep[k]) begin
            logic [15:0] p;
            int n;
            p = sweep[k];
            n = bcd2int(p);
            set_period(p);
            ticks(n - 1);
            check($sformatf("R3 R7 no early flag p=%04h", p), wdog_flag, 0);
            tick_once();
            check($sformatf("R3 R7 flag at N p=%04h", p), wdog_flag, 1);
            check($sformatf("R3 irq at N p=%04h", p), wdog_irq, 1);
            acc(1'b0, 4'hB, 8'h00, rd);
            check($sformatf("R9 status p=%04h", p), rd, 8'h02);
            check($sformatf("R9 read B keeps flag p=%04h", p), wdog_flag, 1);
            acc(1'b0, 4'hC, 8'h00, rd);
            check($sformatf("R5 read C p=%04h", p), rd, {24'h0, p[7:0]});
            idle(1);
            check($sformatf("R2 read clears p=%04h", p), wdog_flag, 0);
            acc(1'b0, 4'hD, 8'h00, rd);
            check($sformatf("R5 read D p=%04h", p), rd, {24'h0, p[15:8]});
            idle(1);
        end

        // R10 level hold, R9 write to status ignored
        set_period(16'h0002);
        ticks(2);
        ticks(4);
        idle(20);
        check("R10 level holds", wdog_flag, 1);
        acc(1'b1, 4'hB, 8'h00, rd);
        idle(1);
        check("R9 write B no clear", wdog_flag, 1);
        acc(1'b0, 4'hC, 8'h00, rd);
        idle(1);
        check("R2 service clears level", wdog_flag, 0);
        acc(1'b1, 4'hB, 8'hFF, rd);
        idle(1);
        check("R9 write B no set", wdog_flag, 0);

        // R10 pulse length, R4 repetition
        pulse_mode = 1'b1;
        set_period(16'h0005);
        ticks(5);
        check("R10 pulse start", wdog_flag, 1);
        idle(PULSE - 1);
        check("R10 pulse last cycle", wdog_flag, 1);
        idle(1);
        check("R10 pulse ended", wdog_flag, 0);
        ticks(4);
        check("R4 no early repeat", wdog_flag, 0);
        tick_once();
        check("R4 repeat alarm", wdog_flag, 1);
        idle(PULSE);
        pulse_mode = 1'b0;

        // R8: tick in the reload cycle is ignored
        set_period(16'h0003);
        ticks(2);
        acc(1'b0, 4'hD, 8'h00, rd);
        tick_once();
        check("R8 tick in reload cycle", wdog_flag, 0);
        ticks(2);
        check("R8 full period needed", wdog_flag, 0);
        tick_once();
        check("R8 alarm after N", wdog_flag, 1);

        // R2: rewrite mid-count reloads from the new value
        set_period(16'h0020);
        ticks(15);
        acc(1'b1, 4'hC, 8'h05, rd);
        idle(1);
        ticks(4);
        check("R2 new period early", wdog_flag, 0);
        tick_once();
        check("R2 new period expiry", wdog_flag, 1);

        // R6: zero period disables
        set_period(16'h0000);
        check("R6 zero clears", wdog_flag, 0);
        ticks(300);
        check("R6 zero never alarms", wdog_flag, 0);
        check("R6 irq stays low", wdog_irq, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule